// File: doc/BRIEF.md
# In-Order Retirement Buffer with Speculative Flush

This block keeps issued instructions in program order while their results come back out of order. At issue it hands out a slot number that serves as the result tag. The slot records one of three kinds of work: a register write, a memory store, or a conditional branch. Results arrive on a shared broadcast bus tagged with that slot number. A store slot also listens on the bus for its data value when the data was not available at issue. The oldest slot retires once its work is complete. At most one slot retires per clock.

A retiring register slot drives a register-file write port, and a retiring store drives a memory write port. A retiring branch that was predicted correctly frees its slot and causes nothing else. A retiring branch that was mispredicted raises a one-cycle flush, gives the restart address, and delivers a predictor update; every slot is discarded. The issue stage can read the completion flag and value of any slot by tag, so it can forward operands that are finished but not yet retired.

Top module: `rob_core`

## Requirements
- R1: The buffer has 6 slots. `issueTag` gives the slot that the next accepted issue takes. Tags run 0,1,2,3,4,5 and then wrap to 0, and an issue is accepted on a clock edge where `issueValid` and `issueReady` are both high.
- R2: `issueReady` is low while 6 slots are live and during a flush cycle. An issue offered while `issueReady` is low allocates nothing.
- R3: A register slot (kind 0) retires only when its own result has arrived on the bus and every older slot has retired. In its retire cycle `regWrEn` is high for one cycle, with the recorded destination on `regWrAddr` and the result on `regWrData`.
- R4: Slots retire strictly in allocation order, at most one per cycle. A completed slot waits behind an incomplete older one.
- R5: A store slot (kind 1) takes its address from the bus result carrying its own tag. It takes its data at issue when `issueDataReady` is high. Otherwise it takes the data from the first bus result whose tag equals `issueDataTag`, and a result on that tag in the issue cycle itself counts.
- R6: A store slot retires only when both its address and its data are present. It then pulses `memWrEn` with the address and data and does not write a register.
- R7: A branch slot (kind 2) records `issuePc` and takes the correct successor address, the taken outcome and a mispredict flag from its bus result. A branch whose mispredict flag is 0 retires with no flush, no write and no predictor update.
- R8: When a branch whose mispredict flag is 1 retires, `flush` and `bpUpdEn` pulse for one cycle. `restartPc` and `bpUpdTarget` carry the successor address, `bpUpdPc` carries the branch address and `bpUpdTaken` carries the outcome. All slots are discarded, the younger slots never retire, and the next tag is 0.
- R9: For each lookup port, `lookupReady` is high only when the slot addressed by the tag is live and has its result, and `lookupValue` is that slot's value field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Issue request |
| issueKind | input | 2 | 0 register, 1 store, 2 branch |
| issueDest | input | 5 | Destination register |
| issuePc | input | 32 | Branch instruction address |
| issueDataReady | input | 1 | Store data present at issue |
| issueData | input | 32 | Store data at issue |
| issueDataTag | input | 3 | Tag producing the store data |
| issueReady | output | 1 | A slot can be allocated |
| issueTag | output | 3 | Slot for the next issue |
| cdbValid | input | 1 | Broadcast bus result valid |
| cdbTag | input | 3 | Tag of the result |
| cdbValue | input | 32 | Result, store address or successor PC |
| cdbMispredict | input | 1 | Branch was mispredicted |
| cdbTaken | input | 1 | Branch outcome |
| lookupTag | input | 6 | Two packed lookup tags |
| lookupReady | output | 2 | Per-port completion flag |
| lookupValue | output | 64 | Two packed values |
| regWrEn | output | 1 | Register write strobe |
| regWrAddr | output | 5 | Register index |
| regWrData | output | 32 | Register data |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 32 | Memory address |
| memWrData | output | 32 | Memory data |
| flush | output | 1 | Discard all speculative state |
| restartPc | output | 32 | Fetch restart address |
| bpUpdEn | output | 1 | Predictor update strobe |
| bpUpdPc | output | 32 | Branch address to update |
| bpUpdTarget | output | 32 | Successor address |
| bpUpdTaken | output | 1 | Outcome to record |

## Verification
A stale head or tail pointer shows as a write whose destination or data belongs to a different instruction. A miscounted occupancy shows as `issueReady` staying high on a full buffer or a wrong `issueTag` after wrap-around. Either shows at the first retirement or issue after the fault. A store that missed its snoop stalls the retire stream or writes memory with old data. A slot that survives a flush later retires without being expected. Each of these faults appears at the write ports within a few cycles, and the scoreboard compares every retire event against the order in which the bench issued work.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;

  typedef struct packed {
    logic alloc;
    logic commit;
    logic flush;
  } rob_strobe_t;

  typedef struct packed {
    logic done;
    logic mispredict;
  } head_stat_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  head_stat_t       headStat,
  output rob_strobe_t      strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic [CNT_W-1:0] occupancy,
  output logic             issueReady
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic notEmpty, isFull;

  function automatic logic [IDX_W-1:0] wrapInc(input logic [IDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    notEmpty      = (occupancy != '0);
    isFull        = (occupancy == FULL_CNT);
    strobe.commit = notEmpty && headStat.done;
    strobe.flush  = strobe.commit && headStat.mispredict;
    issueReady    = !isFull && !strobe.flush;
    strobe.alloc  = issueValid && issueReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      occupancy <= '0;
    end else if (strobe.flush) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      occupancy <= '0;
    end else begin
      if (strobe.commit) headIdx <= wrapInc(headIdx);
      if (strobe.alloc)  tailIdx <= wrapInc(tailIdx);
      case ({strobe.alloc, strobe.commit})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int IDX_W    = 3,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rob_strobe_t                  strobe,
  input  logic [IDX_W-1:0]             headIdx,
  input  logic [IDX_W-1:0]             tailIdx,
  input  logic [1:0]                   issueKind,
  input  logic [REG_W-1:0]             issueDest,
  input  logic [DATA_W-1:0]            issuePc,
  input  logic                         issueDataReady,
  input  logic [DATA_W-1:0]            issueData,
  input  logic [IDX_W-1:0]             issueDataTag,
  input  logic                         cdbValid,
  input  logic [IDX_W-1:0]             cdbTag,
  input  logic [DATA_W-1:0]            cdbValue,
  input  logic                         cdbMispredict,
  input  logic                         cdbTaken,
  input  logic [RD_PORTS*IDX_W-1:0]    lookupTag,
  output logic [RD_PORTS-1:0]          lookupReady,
  output logic [RD_PORTS*DATA_W-1:0]   lookupValue,
  output head_stat_t                   headStat,
  output logic                         regWrEn,
  output logic [REG_W-1:0]             regWrAddr,
  output logic [DATA_W-1:0]            regWrData,
  output logic                         memWrEn,
  output logic [DATA_W-1:0]            memWrAddr,
  output logic [DATA_W-1:0]            memWrData,
  output logic                         flush,
  output logic [DATA_W-1:0]            restartPc,
  output logic                         bpUpdEn,
  output logic [DATA_W-1:0]            bpUpdPc,
  output logic [DATA_W-1:0]            bpUpdTarget,
  output logic                         bpUpdTaken
);
  logic              slotLive  [DEPTH];
  kind_e             slotKind  [DEPTH];
  logic [REG_W-1:0]  slotDest  [DEPTH];
  logic [DATA_W-1:0] slotAddr  [DEPTH];
  logic [DATA_W-1:0] slotValue [DEPTH];
  logic              slotDone  [DEPTH];
  logic              slotHasData [DEPTH];
  logic [IDX_W-1:0]  slotSrcTag  [DEPTH];
  logic              slotMisp  [DEPTH];
  logic              slotTaken [DEPTH];

  kind_e newKind;
  logic  sameCycleData;
  assign newKind       = kind_e'(issueKind);
  assign sameCycleData = cdbValid && (cdbTag == issueDataTag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        slotLive[i]    <= 1'b0;
        slotKind[i]    <= KIND_REG;
        slotDest[i]    <= '0;
        slotAddr[i]    <= '0;
        slotValue[i]   <= '0;
        slotDone[i]    <= 1'b0;
        slotHasData[i] <= 1'b0;
        slotSrcTag[i]  <= '0;
        slotMisp[i]    <= 1'b0;
        slotTaken[i]   <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.flush) begin
          slotLive[i] <= 1'b0;
        end else if (strobe.alloc && tailIdx == IDX_W'(i)) begin
          slotLive[i]    <= 1'b1;
          slotKind[i]    <= newKind;
          slotDest[i]    <= issueDest;
          slotAddr[i]    <= issuePc;
          slotDone[i]    <= 1'b0;
          slotSrcTag[i]  <= issueDataTag;
          slotMisp[i]    <= 1'b0;
          slotTaken[i]   <= 1'b0;
          if (newKind == KIND_STORE && !issueDataReady && sameCycleData) begin
            slotValue[i]   <= cdbValue;
            slotHasData[i] <= 1'b1;
          end else begin
            slotValue[i]   <= issueData;
            slotHasData[i] <= (newKind != KIND_STORE) || issueDataReady;
          end
        end else if (slotLive[i]) begin
          if (strobe.commit && headIdx == IDX_W'(i)) slotLive[i] <= 1'b0;
          if (cdbValid && cdbTag == IDX_W'(i) && !slotDone[i]) begin
            slotDone[i] <= 1'b1;
            case (slotKind[i])
              KIND_STORE:  slotAddr[i] <= cdbValue;
              KIND_BRANCH: begin
                slotValue[i] <= cdbValue;
                slotMisp[i]  <= cdbMispredict;
                slotTaken[i] <= cdbTaken;
              end
              default:     slotValue[i] <= cdbValue;
            endcase
          end
          if (slotKind[i] == KIND_STORE && !slotHasData[i] &&
              cdbValid && cdbTag == slotSrcTag[i]) begin
            slotValue[i]   <= cdbValue;
            slotHasData[i] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    headStat.done       = slotLive[headIdx] && slotDone[headIdx] && slotHasData[headIdx];
    headStat.mispredict = (slotKind[headIdx] == KIND_BRANCH) && slotMisp[headIdx];
    regWrEn     = strobe.commit && (slotKind[headIdx] == KIND_REG);
    regWrAddr   = slotDest[headIdx];
    regWrData   = slotValue[headIdx];
    memWrEn     = strobe.commit && (slotKind[headIdx] == KIND_STORE);
    memWrAddr   = slotAddr[headIdx];
    memWrData   = slotValue[headIdx];
    flush       = strobe.flush;
    restartPc   = slotValue[headIdx];
    bpUpdEn     = strobe.flush;
    bpUpdPc     = slotAddr[headIdx];
    bpUpdTarget = slotValue[headIdx];
    bpUpdTaken  = slotTaken[headIdx];
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_lookup
    logic [IDX_W-1:0] rawTag, safeTag;
    logic             inRange;
    assign rawTag  = lookupTag[p*IDX_W +: IDX_W];
    assign inRange = (rawTag < IDX_W'(DEPTH));
    assign safeTag = inRange ? rawTag : '0;
    assign lookupReady[p] = inRange && slotLive[safeTag] && slotDone[safeTag];
    assign lookupValue[p*DATA_W +: DATA_W] = slotValue[safeTag];
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issueValid,
  input  logic [1:0]                 issueKind,
  input  logic [REG_W-1:0]           issueDest,
  input  logic [DATA_W-1:0]          issuePc,
  input  logic                       issueDataReady,
  input  logic [DATA_W-1:0]          issueData,
  input  logic [IDX_W-1:0]           issueDataTag,
  output logic                       issueReady,
  output logic [IDX_W-1:0]           issueTag,
  input  logic                       cdbValid,
  input  logic [IDX_W-1:0]           cdbTag,
  input  logic [DATA_W-1:0]          cdbValue,
  input  logic                       cdbMispredict,
  input  logic                       cdbTaken,
  input  logic [RD_PORTS*IDX_W-1:0]  lookupTag,
  output logic [RD_PORTS-1:0]        lookupReady,
  output logic [RD_PORTS*DATA_W-1:0] lookupValue,
  output logic                       regWrEn,
  output logic [REG_W-1:0]           regWrAddr,
  output logic [DATA_W-1:0]          regWrData,
  output logic                       memWrEn,
  output logic [DATA_W-1:0]          memWrAddr,
  output logic [DATA_W-1:0]          memWrData,
  output logic                       flush,
  output logic [DATA_W-1:0]          restartPc,
  output logic                       bpUpdEn,
  output logic [DATA_W-1:0]          bpUpdPc,
  output logic [DATA_W-1:0]          bpUpdTarget,
  output logic                       bpUpdTaken
);
  rob_strobe_t      strobe;
  head_stat_t       headStat;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic [CNT_W-1:0] occupancy;

  assign issueTag = tailIdx;

  rob_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .headStat(headStat),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .occupancy(occupancy), .issueReady(issueReady)
  );

  rob_data #(.DEPTH(DEPTH), .IDX_W(IDX_W), .REG_W(REG_W), .DATA_W(DATA_W),
             .RD_PORTS(RD_PORTS)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .issueKind(issueKind), .issueDest(issueDest), .issuePc(issuePc),
    .issueDataReady(issueDataReady), .issueData(issueData), .issueDataTag(issueDataTag),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbValue(cdbValue),
    .cdbMispredict(cdbMispredict), .cdbTaken(cdbTaken),
    .lookupTag(lookupTag), .lookupReady(lookupReady), .lookupValue(lookupValue),
    .headStat(headStat),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .flush(flush), .restartPc(restartPc), .bpUpdEn(bpUpdEn), .bpUpdPc(bpUpdPc),
    .bpUpdTarget(bpUpdTarget), .bpUpdTaken(bpUpdTaken)
  );
endmodule

// File: rtl/rob_check.sv
module rob_check #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] occupancy,
  input logic             issueValid,
  input logic             issueReady,
  input logic [IDX_W-1:0] issueTag,
  input logic             regWrEn,
  input logic             memWrEn,
  input logic             flush,
  input logic             bpUpdEn
);
  a_r2_stall_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == CNT_W'(DEPTH)) |-> !issueReady);

  a_r1_bounded_fill: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH));

  a_r1_tag_in_range: assert property (@(posedge clk) disable iff (!rstN)
    issueTag < IDX_W'(DEPTH));

  a_r4_one_retire: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, memWrEn, flush}));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (occupancy == '0) && (issueTag == '0));

  a_r8_update_with_flush: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> bpUpdEn);

  a_r2_rejected_issue_holds_tag: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueReady && !flush && !regWrEn && !memWrEn) |=> $stable(issueTag));
endmodule

bind rob_core rob_check #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .occupancy(occupancy), .issueValid(issueValid),
  .issueReady(issueReady), .issueTag(issueTag), .regWrEn(regWrEn),
  .memWrEn(memWrEn), .flush(flush), .bpUpdEn(bpUpdEn)
);

// File: tb/rob_core_test.sv
module rob_core_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        issueValid = 0;
  logic [1:0]  issueKind = 0;
  logic [4:0]  issueDest = 0;
  logic [31:0] issuePc = 0;
  logic        issueDataReady = 0;
  logic [31:0] issueData = 0;
  logic [2:0]  issueDataTag = 0;
  logic        issueReady;
  logic [2:0]  issueTag;
  logic        cdbValid = 0;
  logic [2:0]  cdbTag = 0;
  logic [31:0] cdbValue = 0;
  logic        cdbMispredict = 0;
  logic        cdbTaken = 0;
  logic [5:0]  lookupTag = 0;
  logic [1:0]  lookupReady;
  logic [63:0] lookupValue;
  logic        regWrEn, memWrEn, flush, bpUpdEn, bpUpdTaken;
  logic [4:0]  regWrAddr;
  logic [31:0] regWrData, memWrAddr, memWrData, restartPc, bpUpdPc, bpUpdTarget;

  always #5 clk = ~clk;

  rob_core uut (.*);

  typedef struct {
    int          ev;   // 0 register write, 1 memory write, 2 flush
    logic [31:0] a;
    logic [31:0] d;
    logic [31:0] x;
    string       req;
  } item_t;

  item_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expectEv(input int ev, input logic [31:0] a, input logic [31:0] d,
                          input logic [31:0] x, input string req);
    item_t it;
    it.ev = ev; it.a = a; it.d = d; it.x = x; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    issueValid = 0; cdbValid = 0; cdbMispredict = 0; cdbTaken = 0;
  endtask

  task automatic issueOp(input logic [1:0] k, input logic [4:0] dst, input logic [31:0] pc,
                         input bit drdy, input logic [31:0] dat, input logic [2:0] dtag);
    issueValid = 1; issueKind = k; issueDest = dst; issuePc = pc;
    issueDataReady = drdy; issueData = dat; issueDataTag = dtag;
  endtask

  task automatic sendCdb(input logic [2:0] t, input logic [31:0] v, input bit mis, input bit tk);
    cdbValid = 1; cdbTag = t; cdbValue = v; cdbMispredict = mis; cdbTaken = tk;
  endtask

  // Monitor: every retire event must match the head of the expected queue.
  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn || memWrEn || flush) begin
        item_t it;
        int ev;
        ev = flush ? 2 : (memWrEn ? 1 : 0);
        if (expQ.size() == 0) begin
          check(0, "R4 unexpected retire", 64'(ev), 64'hFF);
        end else begin
          it = expQ.pop_front();
          check(ev == it.ev, it.req, 64'(ev), 64'(it.ev));
          if (ev == 0) begin
            check(32'(regWrAddr) == it.a, it.req, 64'(regWrAddr), 64'(it.a));
            check(regWrData == it.d, it.req, 64'(regWrData), 64'(it.d));
          end else if (ev == 1) begin
            check(memWrAddr == it.a, it.req, 64'(memWrAddr), 64'(it.a));
            check(memWrData == it.d, it.req, 64'(memWrData), 64'(it.d));
          end else begin
            check(restartPc == it.a && bpUpdTarget == it.a, it.req, 64'(restartPc), 64'(it.a));
            check(bpUpdPc == it.d, it.req, 64'(bpUpdPc), 64'(it.d));
            check(32'(bpUpdTaken) == it.x && bpUpdEn, it.req, 64'(bpUpdTaken), 64'(it.x));
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check(0, "watchdog", 64'(cycles), 64'd20000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    // Reset state
    check(issueReady == 1, "R2 reset ready", 64'(issueReady), 1);
    check(issueTag == 0, "R1 reset tag", 64'(issueTag), 0);
    check(!regWrEn && !memWrEn && !flush, "R4 reset idle", 64'({regWrEn, memWrEn, flush}), 0);

    // Fill all six slots with register work; tags must run 0..5
    for (int i = 0; i < 6; i++) begin
      check(issueTag == 3'(i), "R1 tag sequence", 64'(issueTag), 64'(i));
      issueOp(2'd0, 5'(i + 1), 0, 0, 0, 0);
      tick();
    end
    check(issueReady == 0, "R2 full stalls", 64'(issueReady), 0);
    issueOp(2'd0, 5'd31, 0, 0, 0, 0);   // offered while full: must be dropped
    tick();

    // Out-of-order completion: slot 2 done first, nothing may retire
    sendCdb(3'd2, 32'h102, 0, 0);
    tick();
    lookupTag = {3'd2, 3'd0};
    #1;
    check(lookupReady[1] == 1, "R9 lookup ready", 64'(lookupReady[1]), 1);
    check(lookupValue[63:32] == 32'h102, "R9 lookup value", 64'(lookupValue[63:32]), 64'h102);
    check(lookupReady[0] == 0, "R9 lookup pending", 64'(lookupReady[0]), 0);
    check(!regWrEn, "R4 younger waits", 64'(regWrEn), 0);

    expectEv(0, 1, 32'h100, 0, "R3 retire slot0");
    sendCdb(3'd0, 32'h100, 0, 0);
    tick();
    expectEv(0, 2, 32'h101, 0, "R4 retire slot1");
    expectEv(0, 3, 32'h102, 0, "R4 retire slot2 after slot1");
    sendCdb(3'd1, 32'h101, 0, 0);
    tick(); tick(); tick();
    for (int i = 3; i < 6; i++) begin
      expectEv(0, 32'(i + 1), 32'h100 + 32'(i), 0, "R3 retire tail");
      sendCdb(3'(i), 32'h100 + 32'(i), 0, 0);
      tick();
    end
    tick(); tick();
    check(issueTag == 0, "R1 wrap to 0", 64'(issueTag), 0);
    check(issueReady == 1, "R2 ready after drain", 64'(issueReady), 1);

    // Store snooping for its data (kind 1)
    issueOp(2'd0, 5'd7, 0, 0, 0, 0);          // slot 0
    tick();
    issueOp(2'd1, 5'd0, 0, 0, 0, 3'd0);       // slot 1, data from slot 0
    tick();
    sendCdb(3'd1, 32'h100, 0, 0);             // store address
    tick();
    expectEv(0, 7, 32'hAB, 0, "R3 producer retire");
    expectEv(1, 32'h100, 32'hAB, 0, "R5 snooped store data");
    sendCdb(3'd0, 32'hAB, 0, 0);
    tick(); tick(); tick();

    // Store with data at issue
    check(issueTag == 2, "R1 tag after stores", 64'(issueTag), 2);
    issueOp(2'd1, 5'd0, 0, 1, 32'h55, 0);     // slot 2
    tick();
    @(negedge clk);
    check(!memWrEn, "R6 store waits for address", 64'(memWrEn), 0);
    expectEv(1, 32'h200, 32'h55, 0, "R6 store with issue data");
    sendCdb(3'd2, 32'h200, 0, 0);
    tick(); tick();

    // Data broadcast in the same cycle as the store issues
    issueOp(2'd0, 5'd9, 0, 0, 0, 0);          // slot 3
    tick();
    issueOp(2'd1, 5'd0, 0, 0, 0, 3'd3);       // slot 4
    sendCdb(3'd3, 32'h77, 0, 0);
    expectEv(0, 9, 32'h77, 0, "R3 producer retire");
    tick();
    expectEv(1, 32'h300, 32'h77, 0, "R5 same-cycle capture");
    sendCdb(3'd4, 32'h300, 0, 0);
    tick(); tick(); tick();

    // Correctly predicted branch (kind 2)
    issueOp(2'd2, 0, 32'h40, 0, 0, 0);        // slot 5
    tick();
    sendCdb(3'd5, 32'h44, 0, 0);
    tick();
    @(negedge clk);
    check(!flush && !bpUpdEn && !regWrEn && !memWrEn, "R7 quiet branch retire",
          64'({flush, bpUpdEn, regWrEn, memWrEn}), 0);
    tick();
    check(issueTag == 0 && issueReady, "R7 slot freed", 64'(issueTag), 0);

    // Mispredicted branch with completed younger work behind it
    issueOp(2'd2, 0, 32'h80, 0, 0, 0);        // slot 0
    tick();
    issueOp(2'd0, 5'd10, 0, 0, 0, 0);         // slot 1
    tick();
    issueOp(2'd0, 5'd11, 0, 0, 0, 0);         // slot 2
    tick();
    sendCdb(3'd1, 32'hA1, 0, 0);
    tick();
    sendCdb(3'd2, 32'hA2, 0, 0);
    tick();
    expectEv(2, 32'h1000, 32'h80, 1, "R8 flush and update");
    sendCdb(3'd0, 32'h1000, 1, 1);
    tick();
    @(negedge clk);
    check(flush == 1, "R8 flush pulse", 64'(flush), 1);
    check(issueReady == 0, "R2 no issue during flush", 64'(issueReady), 0);
    issueOp(2'd0, 5'd13, 0, 0, 0, 0);         // offered during flush: dropped
    tick();
    check(issueTag == 0, "R8 tag restarts", 64'(issueTag), 0);
    lookupTag = {3'd2, 3'd1};
    #1;
    check(lookupReady == 2'b00, "R8 younger discarded", 64'(lookupReady), 0);
    issueOp(2'd0, 5'd12, 0, 0, 0, 0);         // slot 0 again
    tick();
    expectEv(0, 12, 32'h99, 0, "R8 fresh work after flush");
    sendCdb(3'd0, 32'h99, 0, 0);
    tick();
    repeat (5) tick();

    check(expQ.size() == 0, "R4 all retires seen", 64'(expQ.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule